// File: doc/BRIEF.md
# USB Endpoint DMA Channel Bank

This block is the DMA engine that sits beside a USB endpoint controller. It holds eight independent channels, each with a start address, a byte count and a 16-bit control word. Software loads these over a simple 32-bit register bus. Writing the control word with its enable bit set launches a transfer. The active channels then share one memory master port. Each request on that port carries a burst address, a byte length and a direction, and completes with a single valid/ready handshake.

A channel's address register is live: it advances by the byte length of every accepted burst. Software can therefore compute progress as the current address minus the start address. A channel raises its bit in a shared status register when its count runs out, or when the memory port flags an error on one of its bursts. A single interrupt line reports any status bit whose channel has interrupt enable set. Reading the status register clears the bits it returned.

Top module: `usbdma_bank`

## Requirements
- R1: After reset every channel register reads 0, the status register reads 0, and `irq` and `mem_req_valid` are low.
- R2: Channel n's registers decode at byte offsets 0x200+16n: control at +0x4, address at +0x8, count at +0xC. The address reads back as written. A count write larger than 0x10000 is stored as 0x10000.
- R3: Writing the control word with bit 0 set starts channel n. Its requests then appear on the memory port at the channel's current address. `mem_req_write` is the inverse of control bit 1 (1 = transmit, which reads memory). A request is held, with stable address and length, until `mem_req_ready`.
- R4: The burst code in control bits 10:9 sets the largest burst: 0 = 4 bytes, 1 = 16 bytes, 2 = 32 bytes, 3 = 64 bytes. Each burst is the smaller of that size and the bytes still to move, so a transfer takes ceil(count/size) bursts.
- R5: Each accepted, error-free burst adds its length to the address register. After completion the address reads as start + count.
- R6: On completion, control bit 0 reads 0, the other control bits keep their written values, and status bit n is set.
- R7: A burst accepted while `mem_err` is high stops the channel. Control bit 8 is set and bit 0 is cleared, the address stays at the failing burst, and status bit n is set. The next control write clears bit 8.
- R8: The status register sits at offset 0x200, with bit n for channel n. A read returns the bits and clears every bit it returned. A bit set in the same cycle as the read is kept for the next read.
- R9: `irq` is high exactly while some status bit n is set and channel n's control bit 3 (interrupt enable) is set.
- R10: Requesting channels share the memory port round-robin, one burst per grant, starting after the last channel served.
- R11: Writing 0 to a channel's control, address and count registers aborts it. It issues no further requests, all three registers read 0, and no status bit is raised.
- R12: Starting a channel whose count is 0 completes it one cycle later without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read-to-clear) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst accepted |
| mem_req_addr | output | 32 | Burst start address |
| mem_req_bytes | output | 7 | Burst length in bytes |
| mem_req_write | output | 1 | 1 = burst writes memory (receive) |
| mem_err | input | 1 | Error on the burst accepted this cycle |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted remaining-byte counter shows up quickly. The very next request carries a wrong `mem_req_bytes`, and the channel finishes too early or too late, which changes the burst count and the final address readback. A wrong address register is visible on the first `mem_req_addr` after the fault. A stuck status or grant bit changes `irq` or the order of addresses on the memory port within one arbitration round, which is at most eight bursts. The bench checks every burst as it is accepted against an arithmetic model of address and remaining length. It sweeps all four burst codes over lengths around each burst boundary.

// File: rtl/usbdma_pkg.sv
package usbdma_pkg;

  // control word field positions (decoded by software and by the channel)
  localparam int CTL_EN    = 0;
  localparam int CTL_TX    = 1;
  localparam int CTL_MULTI = 2;
  localparam int CTL_IE    = 3;
  localparam int CTL_EP_LO = 4;
  localparam int CTL_BERR  = 8;
  localparam int CTL_BM_LO = 9;

  typedef enum logic [1:0] {
    BM_SINGLE = 2'd0,
    BM_INC4   = 2'd1,
    BM_INC8   = 2'd2,
    BM_INC16  = 2'd3
  } burst_code_e;

  // beats per burst for a burst code
  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (burst_code_e'(code))
      BM_INC4:  burst_beats = 5'd4;
      BM_INC8:  burst_beats = 5'd8;
      BM_INC16: burst_beats = 5'd16;
      default:  burst_beats = 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/usbdma_chan.sv
module usbdma_chan
  import usbdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int MAX_XFER   = 65536,
  parameter int BEAT_BYTES = 4,
  localparam int CW        = $clog2(MAX_XFER + 1),
  localparam int BYTEW     = $clog2(16 * BEAT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_adr,
  input  logic             wr_cnt,
  input  logic [DW-1:0]    wdata,
  input  logic             hs,
  input  logic             bus_err,
  output logic [15:0]      ctl_o,
  output logic [AW-1:0]    addr_o,
  output logic [CW-1:0]    cnt_o,
  output logic             req_o,
  output logic [BYTEW-1:0] step_o,
  output logic             fin_o
);

  logic            en_q, en_d, tx_q, tx_d, mp_q, mp_d, ie_q, ie_d, berr_q, berr_d;
  logic [3:0]      ep_q, ep_d;
  logic [1:0]      bm_q, bm_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [CW-1:0]   cnt_q, cnt_d, rem_q, rem_d;
  logic [BYTEW-1:0] bmax, step;
  logic            fin;

  // burst size limited by the bytes left
  always_comb begin
    bmax = BYTEW'(int'(burst_beats(bm_q)) * BEAT_BYTES);
    if (rem_q < CW'(bmax)) step = BYTEW'(rem_q);
    else                   step = bmax;
  end

  // next state
  always_comb begin
    en_d   = en_q;   tx_d = tx_q;   mp_d = mp_q;   ie_d = ie_q;
    berr_d = berr_q; ep_d = ep_q;   bm_d = bm_q;
    addr_d = addr_q; cnt_d = cnt_q; rem_d = rem_q;
    fin    = 1'b0;
    if (en_q && hs) begin
      if (bus_err) begin
        berr_d = 1'b1;
        en_d   = 1'b0;
        fin    = 1'b1;
      end else begin
        addr_d = addr_q + AW'(step);
        rem_d  = rem_q - CW'(step);
        if (rem_q == CW'(step)) begin
          en_d = 1'b0;
          fin  = 1'b1;
        end
      end
    end else if (en_q && (rem_q == '0)) begin
      en_d = 1'b0;
      fin  = 1'b1;
    end
    if (wr_adr) addr_d = AW'(wdata);
    if (wr_cnt) begin
      if (wdata > DW'(MAX_XFER)) cnt_d = CW'(MAX_XFER);
      else                       cnt_d = CW'(wdata);
    end
    if (wr_ctl) begin
      en_d   = wdata[CTL_EN];
      tx_d   = wdata[CTL_TX];
      mp_d   = wdata[CTL_MULTI];
      ie_d   = wdata[CTL_IE];
      ep_d   = wdata[CTL_EP_LO +: 4];
      bm_d   = wdata[CTL_BM_LO +: 2];
      berr_d = 1'b0;
      rem_d  = cnt_q;
      fin    = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0; tx_q <= 1'b0; mp_q <= 1'b0; ie_q <= 1'b0;
      berr_q <= 1'b0; ep_q <= '0;   bm_q <= '0;
      addr_q <= '0;   cnt_q <= '0;  rem_q <= '0;
    end else begin
      en_q   <= en_d;   tx_q <= tx_d; mp_q <= mp_d; ie_q <= ie_d;
      berr_q <= berr_d; ep_q <= ep_d; bm_q <= bm_d;
      addr_q <= addr_d; cnt_q <= cnt_d; rem_q <= rem_d;
    end
  end

  assign ctl_o  = {5'b0, bm_q, berr_q, ep_q, ie_q, mp_q, tx_q, en_q};
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign req_o  = en_q && (rem_q != '0);
  assign step_o = step;
  assign fin_o  = fin;

  // R5
  addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && hs && !bus_err && !wr_adr) |=> (addr_o == $past(addr_o) + AW'($past(step))));

  // R7
  berr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && hs && bus_err && !wr_ctl && !wr_adr) |=>
      (ctl_o[CTL_BERR] && !ctl_o[CTL_EN] && $stable(addr_o)));

  // R2
  cnt_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CW'(MAX_XFER));

endmodule

// File: rtl/usbdma_arb.sv
module usbdma_arb #(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           hs,
  output logic           gnt_v,
  output logic [IW-1:0]  gnt_idx
);

  logic          gv_q, gv_d;
  logic [IW-1:0] gi_q, gi_d, last_q, last_d;
  logic [IW-1:0] pick;
  logic          found;

  // next requester after the last one served
  always_comb begin
    found = 1'b0;
    pick  = last_q;
    for (int k = 1; k <= NCH; k++) begin
      if (!found && req[(int'(last_q) + k) % NCH]) begin
        found = 1'b1;
        pick  = IW'((int'(last_q) + k) % NCH);
      end
    end
  end

  always_comb begin
    gv_d   = gv_q;
    gi_d   = gi_q;
    last_d = last_q;
    if (gv_q) begin
      if (hs || !req[gi_q]) gv_d = 1'b0;
    end else if (found) begin
      gv_d   = 1'b1;
      gi_d   = pick;
      last_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q   <= 1'b0;
      gi_q   <= '0;
      last_q <= IW'(NCH - 1);
    end else begin
      gv_q   <= gv_d;
      gi_q   <= gi_d;
      last_q <= last_d;
    end
  end

  assign gnt_v   = gv_q;
  assign gnt_idx = gi_q;

  // R10
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gv_q && !hs && req[gi_q]) |=> (gv_q && $stable(gi_q)));

endmodule

// File: rtl/usbdma_irq.sv
module usbdma_irq #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] fin,
  input  logic [NCH-1:0] ie,
  input  logic           rd_stat,
  output logic [NCH-1:0] stat_o,
  output logic           irq_o
);

  logic [NCH-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = (rd_stat ? '0 : stat_q) | fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ie);

  // R8
  fin_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fin) |=> ((stat_o & $past(fin)) == $past(fin)));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !(|fin)) |=> (stat_o == '0));

endmodule

// File: rtl/usbdma_bank.sv
module usbdma_bank
  import usbdma_pkg::*;
#(
  parameter int          NCH        = 8,
  parameter int          AW         = 32,
  parameter int          RAW        = 12,
  parameter int          MAX_XFER   = 65536,
  parameter int          BEAT_BYTES = 4,
  parameter logic [11:0] WIN_BASE   = 12'h200,
  localparam int         IW         = $clog2(NCH),
  localparam int         CW         = $clog2(MAX_XFER + 1),
  localparam int         BYTEW      = $clog2(16 * BEAT_BYTES + 1),
  localparam int         WINB       = IW + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  output logic [BYTEW-1:0] mem_req_bytes,
  output logic             mem_req_write,
  input  logic             mem_err,
  output logic             irq
);

  logic [15:0]      ctl_a  [NCH];
  logic [AW-1:0]    addr_a [NCH];
  logic [CW-1:0]    cnt_a  [NCH];
  logic [BYTEW-1:0] step_a [NCH];
  logic [NCH-1:0]   req_v, fin_v, ie_v, stat;
  logic             in_win, rd_stat, gnt_v, hs;
  logic [IW-1:0]    ch_sel, gnt_idx;
  logic [3:0]       off;

  // window decode
  assign in_win  = (reg_addr >> WINB) == RAW'(WIN_BASE >> WINB);
  assign ch_sel  = reg_addr[WINB-1:4];
  assign off     = reg_addr[3:0];
  assign rd_stat = reg_rd && in_win && (ch_sel == '0) && (off == 4'h0);

  assign mem_req_valid = gnt_v && req_v[gnt_idx];
  assign mem_req_addr  = addr_a[gnt_idx];
  assign mem_req_bytes = step_a[gnt_idx];
  assign mem_req_write = !ctl_a[gnt_idx][CTL_TX];
  assign hs            = mem_req_valid && mem_req_ready;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel = reg_wr && in_win && (ch_sel == IW'(n));
    usbdma_chan #(
      .AW(AW), .DW(32), .MAX_XFER(MAX_XFER), .BEAT_BYTES(BEAT_BYTES)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (sel && (off == 4'h4)),
      .wr_adr  (sel && (off == 4'h8)),
      .wr_cnt  (sel && (off == 4'hC)),
      .wdata   (reg_wdata),
      .hs      (hs && (gnt_idx == IW'(n))),
      .bus_err (mem_err),
      .ctl_o   (ctl_a[n]),
      .addr_o  (addr_a[n]),
      .cnt_o   (cnt_a[n]),
      .req_o   (req_v[n]),
      .step_o  (step_a[n]),
      .fin_o   (fin_v[n])
    );
    assign ie_v[n] = ctl_a[n][CTL_IE];
  end

  usbdma_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_v),
    .hs      (hs),
    .gnt_v   (gnt_v),
    .gnt_idx (gnt_idx)
  );

  usbdma_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin     (fin_v),
    .ie      (ie_v),
    .rd_stat (rd_stat),
    .stat_o  (stat),
    .irq_o   (irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (in_win) begin
      if ((ch_sel == '0) && (off == 4'h0)) reg_rdata = 32'(stat);
      for (int n = 0; n < NCH; n++) begin
        if (ch_sel == IW'(n)) begin
          case (off)
            4'h4:    reg_rdata = 32'(ctl_a[n]);
            4'h8:    reg_rdata = 32'(addr_a[n]);
            4'hC:    reg_rdata = 32'(cnt_a[n]);
            default: ;
          endcase
        end
      end
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !reg_wr) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_bytes)));

endmodule

// File: tb/usbdma_bank_test.sv
module usbdma_bank_test;

  logic        clk = 1'b0;
  logic        rst_n, reg_wr, reg_rd, mem_req_valid, mem_req_ready, mem_req_write, mem_err, irq;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_req_addr;
  logic [6:0]  mem_req_bytes;

  always #2 clk = ~clk;

  usbdma_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
    .mem_req_write(mem_req_write), .mem_err(mem_err), .irq(irq)
  );

  int          nchk = 0, nfail = 0;
  logic [31:0] exp_addr [8];
  int          exp_rem [8], bb [8], nburst [8];
  logic        txv [8];
  int          log_ch [64];
  int          nlog = 0;
  bit          saw_valid = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // burst monitor: model of address and remaining bytes per channel
  always @(negedge clk) begin
    int c, e;
    if (rst_n === 1'b1) begin
      if (mem_req_valid) saw_valid = 1;
      if (mem_req_valid && mem_req_ready) begin
        c = int'(mem_req_addr[22:20]);
        e = (exp_rem[c] < bb[c]) ? exp_rem[c] : bb[c];
        check("R5 burst address", mem_req_addr, exp_addr[c]);
        check("R4 burst bytes", 32'(mem_req_bytes), 32'(e));
        check("R3 direction", 32'(mem_req_write), 32'(!txv[c]));
        if (!mem_err) begin
          exp_addr[c] = exp_addr[c] + 32'(e);
          exp_rem[c]  = exp_rem[c] - e;
        end
        nburst[c]++;
        if (nlog < 64) begin
          log_ch[nlog] = c;
          nlog++;
        end
      end
    end
  end

  function automatic logic [11:0] ca(input int ch, input int o);
    return 12'(32'h200 + ch * 16 + o);
  endfunction

  function automatic logic [31:0] mkctl(input int tx, input int ie, input int ep, input int code);
    return 32'(1 | (tx << 1) | (1 << 2) | (ie << 3) | ((ep & 15) << 4) | (code << 9));
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] base, input int cnt, input logic [31:0] ctl);
    wr(ca(ch, 8), base);
    wr(ca(ch, 12), 32'(cnt));
    exp_addr[ch] = base;
    exp_rem[ch]  = cnt;
    bb[ch]       = 4 << (2 * int'(ctl[10:9])) >> ((ctl[10:9] != 0) ? 0 : 0);
    if (ctl[10:9] == 2'd0) bb[ch] = 4;
    else if (ctl[10:9] == 2'd1) bb[ch] = 16;
    else if (ctl[10:9] == 2'd2) bb[ch] = 32;
    else bb[ch] = 64;
    txv[ch]    = ctl[1];
    nburst[ch] = 0;
    wr(ca(ch, 4), ctl);
  endtask

  task automatic wait_idle(input int ch);
    logic [31:0] d;
    for (int k = 0; k < 3000; k++) begin
      rd(ca(ch, 4), d);
      if (!d[0]) return;
    end
    check("R6 channel finishes", d, 32'(d & ~32'h1));
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d, w;
    int counts [11] = '{1, 3, 4, 5, 15, 16, 17, 33, 64, 65, 100};
    int pat [3] = '{0, 2, 5};
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_req_ready = 1'b0; mem_err = 1'b0;
    for (int i = 0; i < 8; i++) begin
      exp_addr[i] = '0; exp_rem[i] = 0; bb[i] = 4; nburst[i] = 0; txv[i] = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 0);
    rd(12'h200, d); check("R1 status", d, 0);
    for (int c = 0; c < 8; c++) begin
      rd(ca(c, 4), d); check("R1 control", d, 0);
      rd(ca(c, 8), d); check("R1 address", d, 0);
      rd(ca(c, 12), d); check("R1 count", d, 0);
    end

    // R2 decode and clamp
    wr(ca(7, 12), 32'h1FFFF); rd(ca(7, 12), d); check("R2 count clamp", d, 32'h10000);
    wr(ca(7, 12), 32'h10000); rd(ca(7, 12), d); check("R2 count max", d, 32'h10000);
    wr(ca(6, 8), 32'h1234_5678); rd(ca(6, 8), d); check("R2 address readback", d, 32'h1234_5678);
    wr(ca(6, 12), 32'h30); rd(ca(6, 12), d); check("R2 count readback", d, 32'h30);
    rd(ca(7, 8), d); check("R2 neighbour untouched", d, 0);

    // R3 R4 R5 R6 R9 sweep over burst codes and lengths
    mem_req_ready = 1'b1;
    for (int code = 0; code < 4; code++) begin
      for (int i = 0; i < 11; i++) begin
        int ch, b;
        logic [31:0] base;
        ch   = code * 2 + (i % 2);
        base = 32'(ch << 20) + 32'(i * 32'h1000) + 32'(code * 32'h100);
        w    = mkctl(i % 2, 1, ch + i, code);
        prog(ch, base, counts[i], w);
        wait_idle(ch);
        b = (code == 0) ? 4 : (code == 1) ? 16 : (code == 2) ? 32 : 64;
        check("R4 burst count", 32'(nburst[ch]), 32'((counts[i] + b - 1) / b));
        rd(ca(ch, 8), d); check("R5 final address", d, base + 32'(counts[i]));
        rd(ca(ch, 4), d); check("R6 control after done", d, w & ~32'h1);
        check("R9 irq with enable", 32'(irq), 1);
        rd(12'h200, d); check("R6 status bit", d, 32'(1 << ch));
        check("R8 irq after clear", 32'(irq), 0);
      end
    end

    // R12 zero count, R8 same-cycle set survives the read
    mem_req_ready = 1'b0;
    saw_valid = 0;
    prog(4, 32'h0040_0000, 0, mkctl(0, 0, 1, 0));
    rd(12'h200, d); check("R8 read in set cycle", d, 0);
    rd(12'h200, d); check("R8 bit kept", d, 32'h10);
    check("R12 no request", 32'(saw_valid), 0);
    rd(ca(4, 4), d); check("R12 enable cleared", d, mkctl(0, 0, 1, 0) & ~32'h1);

    // R9 interrupt enable gating
    prog(4, 32'h0040_0000, 0, mkctl(0, 0, 1, 0));
    repeat (3) @(posedge clk); #1;
    check("R9 irq masked", 32'(irq), 0);
    prog(5, 32'h0050_0000, 0, mkctl(0, 1, 2, 0));
    repeat (3) @(posedge clk); #1;
    check("R9 irq enabled", 32'(irq), 1);
    rd(12'h200, d); check("R9 status both", d, 32'h30);
    #1 check("R9 irq after read", 32'(irq), 0);

    // R7 bus error
    mem_err = 1'b1; mem_req_ready = 1'b1;
    w = mkctl(1, 1, 3, 1);
    prog(3, 32'h0030_0040, 64, w);
    wait_idle(3);
    mem_err = 1'b0;
    rd(ca(3, 4), d); check("R7 error flag", d, (w & ~32'h1) | 32'h100);
    rd(ca(3, 8), d); check("R7 address held", d, 32'h0030_0040);
    check("R7 one burst", 32'(nburst[3]), 1);
    rd(12'h200, d); check("R7 status bit", d, 32'h08);
    wr(ca(3, 4), w & ~32'h1);
    rd(ca(3, 4), d); check("R7 flag cleared by write", d, w & ~32'h1);

    // R11 abort
    mem_req_ready = 1'b0;
    prog(1, 32'h0010_0000, 32'h10000, mkctl(0, 1, 1, 0));
    repeat (4) @(posedge clk); #1;
    check("R3 request raised", 32'(mem_req_valid), 1);
    wr(ca(1, 4), 0); wr(ca(1, 8), 0); wr(ca(1, 12), 0);
    repeat (2) @(posedge clk); #1;
    check("R11 request dropped", 32'(mem_req_valid), 0);
    mem_req_ready = 1'b1;
    repeat (6) @(posedge clk); #1;
    mem_req_ready = 1'b0;
    check("R11 no burst", 32'(nburst[1]), 0);
    rd(ca(1, 4), d); check("R11 control", d, 0);
    rd(ca(1, 8), d); check("R11 address", d, 0);
    rd(ca(1, 12), d); check("R11 count", d, 0);
    rd(12'h200, d); check("R11 no status", d, 0);
    check("R11 irq", 32'(irq), 0);

    // R10 round-robin
    nlog = 0;
    prog(0, 32'h0000_0000, 16, mkctl(0, 0, 0, 0));
    prog(2, 32'h0020_0000, 16, mkctl(1, 0, 0, 0));
    prog(5, 32'h0050_0000, 16, mkctl(0, 0, 0, 0));
    mem_req_ready = 1'b1;
    wait_idle(0); wait_idle(2); wait_idle(5);
    check("R10 burst total", 32'(nlog), 12);
    for (int k = 0; k < 12; k++) check("R10 grant order", 32'(log_ch[k]), 32'(pat[k % 3]));
    rd(12'h200, d); check("R10 status", d, 32'h25);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule